// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block models a two-wire serial EEPROM as a synthesizable slave that runs on a fast system clock and oversamples the bus clock and bus data lines. A master first sends a device byte. Its upper nibble is a fixed type code, the next three bits must equal the three strap inputs, and its last bit selects read or write. For a write, the master then sends two word-address bytes and up to 64 data bytes. Those bytes collect in a page buffer. The STOP that ends the write launches a timed internal programming cycle. During that cycle the slave does not acknowledge its device byte, so a master can poll until the cycle is over. A read returns bytes from a 14-bit pointer that advances after every byte.

A write-protect input guards each write. The guard window opens at the clock rise that samples the last bit of the first data byte and stays open until programming ends. If protect is high before the STOP, the write never starts. If protect rises while programming is running, programming stops at once. Every buffered location then holds a fixed corruption pattern, and a flag output reports the damage.

The controller has nine states. `ST_IDLE` waits for a START. A START moves any state to `ST_DEV`, and a STOP returns any state to `ST_IDLE`. `ST_DEV` receives the device byte: a match goes to `ST_SACK`, a mismatch or a busy array goes to `ST_SKIP`. `ST_SACK` drives the acknowledge bit. When that bit ends it moves to `ST_AHI`, `ST_ALO`, `ST_WDAT` or `ST_RDAT`, following the return state latched earlier. `ST_AHI` and `ST_ALO` take the two address bytes, and `ST_WDAT` takes data bytes, each one followed by `ST_SACK`. `ST_RDAT` shifts a read byte out. `ST_MACK` samples the master's answer: an acknowledge returns to `ST_RDAT`, a not-acknowledge goes to `ST_SKIP`. `ST_SKIP` waits for the next START or STOP.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset every location reads 0xFF, SDA is released (`sda_oe` = 0) and `corrupt_o` is low.
- R2: The device byte is, MSB first, 1010, then strap bits [2:0], then R/W (1 = read). It is acknowledged only when all seven upper bits match and no programming cycle is running. Otherwise the slave leaves SDA released for that byte and for the rest of the transaction.
- R3: SDA is sampled on the SCL rising edge. The slave changes its drive on SDA only after an SCL falling edge, or after a START or STOP, and never while SCL stays high.
- R4: A write sends an address-high byte, whose low six bits are address[13:8] and whose top two bits are ignored, then an address-low byte, then data. A single data byte is stored at that address.
- R5: In a multi-byte write, the low six address bits advance and wrap inside the current 64-byte page, and address bits [13:6] stay fixed.
- R6: A programming cycle begins only at the STOP that ends a write carrying at least one data byte. It lasts `WR_CYCLES` clocks, and while it runs the device byte is not acknowledged.
- R7: A random read (address write, repeated START, read) returns the byte at that address. Each further acknowledged byte comes from the next address, and the address wraps from 0x3FFF to 0x0000.
- R8: A master not-acknowledge ends a read. A later read that sends no address starts at the last address read plus one.
- R9: If write-protect is high at any time between the rise sampling bit 0 of the first data byte and the STOP, no programming cycle runs, memory is unchanged, and the next device byte is acknowledged at once.
- R10: If write-protect goes high during programming, the cycle ends at once and every buffered location reads `CORRUPT` (default 0xE7). `corrupt_o` then stays high until the next programming cycle starts.
- R11: A write transaction that carries no data byte before its STOP only loads the pointer and starts no programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 3 | Address strap bits compared with device byte bits [3:1] |
| wp_i | input | 1 | Write protect, active high |
| corrupt_o | output | 1 | High after programming was aborted by write protect |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a START or a STOP. They also assume that it never makes a START or STOP while the slave is pulling SDA low, and that SCL levels last longer than the synchronizer delay. The bench master holds each SCL phase for ten system clocks and changes SDA one phase before each rise. It ends every acknowledged read with a not-acknowledge before the STOP. Write-protect pulses are placed well inside the data phase or the programming phase, and never on the clock where programming starts.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_SACK,
        ST_RDAT,
        ST_MACK,
        ST_SKIP
    } eep_state_t;

    typedef enum logic {
        ARR_IDLE,
        ARR_PROG
    } arr_state_t;

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_s,
    output logic wp_s
);

    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic [1:0] wp_sync;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            wp_sync  <= 2'b00;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            wp_sync  <= {wp_sync[0], wp_i};
            scl_q    <= scl_sync[1];
            sda_q    <= sda_sync[1];
        end
    end

    assign sda_s    = sda_sync[1];
    assign wp_s     = wp_sync[1];
    assign scl_rise = scl_sync[1] & ~scl_q;
    assign scl_fall = ~scl_sync[1] & scl_q;
    assign start_ev = scl_sync[1] & scl_q & sda_q & ~sda_sync[1];
    assign stop_ev  = scl_sync[1] & scl_q & ~sda_q & sda_sync[1];

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PG_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      we,
    input  logic [PG_W-1:0]           idx,
    input  logic [7:0]                din,
    output logic [(8<<PG_W)-1:0]      data_o,
    output logic [(1<<PG_W)-1:0]      mask_o
);

    localparam int PAGE = 1 << PG_W;

    for (genvar g = 0; g < PAGE; g++) begin : g_ent
        logic [7:0] ent;
        logic       vld;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent <= 8'h00;
                vld <= 1'b0;
            end else if (clr) begin
                vld <= 1'b0;
            end else if (we && idx == PG_W'(g)) begin
                ent <= din;
                vld <= 1'b1;
            end
        end

        assign data_o[g*8 +: 8] = ent;
        assign mask_o[g]        = vld;
    end

endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int         AW        = 11,
    parameter int         PTR_W     = 14,
    parameter int         PG_W      = 6,
    parameter int         WR_CYCLES = 400,
    parameter logic [7:0] CORRUPT   = 8'hE7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [PTR_W-PG_W-1:0]     page_i,
    input  logic [(8<<PG_W)-1:0]      pg_data_i,
    input  logic [(1<<PG_W)-1:0]      pg_mask_i,
    input  logic                      wp_i,
    input  logic [AW-1:0]             rd_addr_i,
    output logic [7:0]                rd_data_o,
    output logic                      busy_o,
    output logic                      corrupt_o
);

    localparam int PAGE  = 1 << PG_W;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [7:0]            mem [DEPTH];
    arr_state_t            st;
    logic [CW-1:0]         cyc;
    logic [PTR_W-PG_W-1:0] base;
    logic                  corrupt_q;

    function automatic logic [AW-1:0] loc(input logic [PTR_W-PG_W-1:0] pb,
                                          input logic [PG_W-1:0] off);
        return AW'({pb, off});
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            st        <= ARR_IDLE;
            cyc       <= '0;
            base      <= '0;
            corrupt_q <= 1'b0;
        end else begin
            unique case (st)
                ARR_IDLE: begin
                    if (go) begin
                        st        <= ARR_PROG;
                        cyc       <= '0;
                        base      <= page_i;
                        corrupt_q <= 1'b0;
                    end
                end
                ARR_PROG: begin
                    if (wp_i) begin
                        for (int i = 0; i < PAGE; i++)
                            if (pg_mask_i[i]) mem[loc(base, PG_W'(i))] <= CORRUPT;
                        corrupt_q <= 1'b1;
                        st        <= ARR_IDLE;
                    end else if (cyc == CW'(WR_CYCLES - 1)) begin
                        for (int i = 0; i < PAGE; i++)
                            if (pg_mask_i[i]) mem[loc(base, PG_W'(i))] <= pg_data_i[i*8 +: 8];
                        st <= ARR_IDLE;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
            endcase
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign busy_o    = (st == ARR_PROG);
    assign corrupt_o = corrupt_q;

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int         MEM_AW    = 11,
    parameter int         PTR_W     = 14,
    parameter int         PG_W      = 6,
    parameter int         WR_CYCLES = 400,
    parameter logic [3:0] DEV_TYPE  = 4'b1010,
    parameter logic [7:0] CORRUPT   = 8'hE7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       corrupt_o
);

    localparam int PAGE = 1 << PG_W;

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_s, wp_s;

    eep_state_t        state;
    eep_state_t        ack_to;
    logic [3:0]        cnt;
    logic [7:0]        sh;
    logic [7:0]        rd_sh;
    logic [PTR_W-1:0]  ptr;
    logic [PG_W-1:0]   widx;
    logic              pend;
    logic              cancel;
    logic              mack;
    logic              wr_go;
    logic              busy;
    logic              byte_done;
    logic              in_sack;
    logic              buf_we;
    logic              buf_clr;
    logic [7:0]        rd_data;
    logic [8*PAGE-1:0] pg_data;
    logic [PAGE-1:0]   pg_mask;

    eep_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .wp_i     (wp_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s),
        .wp_s     (wp_s)
    );

    eep_page_buf #(.PG_W(PG_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .we     (buf_we),
        .idx    (widx),
        .din    (sh),
        .data_o (pg_data),
        .mask_o (pg_mask)
    );

    eep_array #(
        .AW        (MEM_AW),
        .PTR_W     (PTR_W),
        .PG_W      (PG_W),
        .WR_CYCLES (WR_CYCLES),
        .CORRUPT   (CORRUPT)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (wr_go),
        .page_i    (ptr[PTR_W-1:PG_W]),
        .pg_data_i (pg_data),
        .pg_mask_i (pg_mask),
        .wp_i      (wp_s),
        .rd_addr_i (ptr[MEM_AW-1:0]),
        .rd_data_o (rd_data),
        .busy_o    (busy),
        .corrupt_o (corrupt_o)
    );

    assign byte_done = scl_fall && (cnt == 4'd8);

    // State register and the datapath that moves with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ack_to <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            rd_sh  <= '0;
            ptr    <= '0;
            widx   <= '0;
            pend   <= 1'b0;
            cancel <= 1'b0;
            mack   <= 1'b0;
            wr_go  <= 1'b0;
        end else begin
            wr_go <= 1'b0;
            if (stop_ev) begin
                state  <= ST_IDLE;
                wr_go  <= pend && !cancel && !wp_s;
                pend   <= 1'b0;
                cancel <= 1'b0;
                cnt    <= '0;
            end else if (start_ev) begin
                state  <= ST_DEV;
                pend   <= 1'b0;
                cancel <= 1'b0;
                cnt    <= '0;
            end else begin
                if (pend && wp_s) cancel <= 1'b1;
                unique case (state)
                    ST_IDLE, ST_SKIP: begin
                    end
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (scl_rise && cnt != 4'd8) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 4'd1;
                            if (state == ST_WDAT && cnt == 4'd7) begin
                                pend <= 1'b1;
                                if (wp_s) cancel <= 1'b1;
                            end
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (sh[7:4] == DEV_TYPE && sh[3:1] == strap_i && !busy) begin
                                    state  <= ST_SACK;
                                    ack_to <= sh[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_AHI) begin
                                ptr[PTR_W-1:8] <= sh[PTR_W-9:0];
                                state          <= ST_SACK;
                                ack_to         <= ST_ALO;
                            end else if (state == ST_ALO) begin
                                ptr[7:0] <= sh;
                                widx     <= sh[PG_W-1:0];
                                state    <= ST_SACK;
                                ack_to   <= ST_WDAT;
                            end else begin
                                widx            <= widx + 1'b1;
                                ptr[PG_W-1:0]   <= widx + 1'b1;
                                state           <= ST_SACK;
                                ack_to          <= ST_WDAT;
                            end
                        end
                    end
                    ST_SACK: begin
                        if (scl_fall) begin
                            cnt   <= '0;
                            state <= ack_to;
                            if (ack_to == ST_RDAT) begin
                                rd_sh <= rd_data;
                                ptr   <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) state <= ST_MACK;
                            else             rd_sh <= {rd_sh[6:0], 1'b0};
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= !sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                rd_sh <= rd_data;
                                ptr   <= ptr + 1'b1;
                                cnt   <= '0;
                                state <= ST_RDAT;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        in_sack = (state == ST_SACK);
        sda_oe  = in_sack || (state == ST_RDAT && !rd_sh[7]);
        buf_we  = (state == ST_WDAT) && byte_done && !start_ev && !stop_ev;
        buf_clr = (state == ST_ALO)  && byte_done && !start_ev && !stop_ev;
    end

endmodule

// File: rtl/eep_i2c_chk.sv
module eep_i2c_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_fall,
    input logic start_ev,
    input logic stop_ev,
    input logic busy,
    input logic wr_go,
    input logic corrupt,
    input logic wp_s,
    input logic in_sack
);

    // R3
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

    // R6
    go_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> $past(stop_ev));

    // R6
    busy_from_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_go));

    // R6
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_sack);

    // R9
    wp_blocks_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !$past(wp_s));

    // R10
    corrupt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corrupt) |-> $past(busy && wp_s));

endmodule

bind eep_i2c_slave eep_i2c_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .busy     (busy),
    .wr_go    (wr_go),
    .corrupt  (corrupt_o),
    .wp_s     (wp_s),
    .in_sack  (in_sack)
);

// File: tb/tb_eep_i2c_slave.sv
`timescale 1ns/1ps
module tb_eep_i2c_slave;

    localparam int Q      = 10;
    localparam int WR     = 2000;
    localparam int MASK   = 2047;
    localparam logic [7:0] DEVW = 8'hAA;
    localparam logic [7:0] DEVR = 8'hAB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       corrupt_o;
    logic       sda_line;
    logic [2:0] strap = 3'b101;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [7:0] ref_mem [0:MASK];
    int  ref_ptr = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eep_i2c_slave #(.WR_CYCLES(WR)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_i   (strap),
        .wp_i      (wp),
        .corrupt_o (corrupt_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b, output logic steady);
        logic b2;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q - 1);
        b2 = sda_line; tick(1);
        steady = (b == b2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output bit ack);
        logic nb, st;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(nb, st);
        ack = !nb;
    endtask

    task automatic rbyte(output logic [7:0] d, input bit ack);
        logic b, st;
        for (int i = 7; i >= 0; i--) begin
            rbit(b, st);
            d[i] = b;
            // R3: data bit held for the whole SCL high phase
            chk(st, "R3", st, 1);
        end
        wbit(!ack);
    endtask

    task automatic ref_put(input int a, input logic [7:0] d[$]);
        for (int i = 0; i < d.size(); i++)
            ref_mem[((a & ~63) | ((a + i) & 63)) & MASK] = d[i];
    endtask

    task automatic read_out(input int n, input string req);
        logic [7:0] got;
        for (int i = 0; i < n; i++) begin
            rbyte(got, i < n - 1);
            chk(got == ref_mem[ref_ptr & MASK], req, got, ref_mem[ref_ptr & MASK]);
            ref_ptr = (ref_ptr + 1) & 16383;
        end
    endtask

    task automatic rd_check(input int a, input int n, input string req);
        bit ack;
        bus_start();
        wbyte(DEVW, ack);
        chk(ack, req, ack, 1);
        wbyte(8'(a >> 8), ack);
        wbyte(8'(a), ack);
        bus_start();
        wbyte(DEVR, ack);
        ref_ptr = a & 16383;
        read_out(n, req);
        bus_stop();
    endtask

    task automatic cur_check(input int n, input string req);
        bit ack;
        bus_start();
        wbyte(DEVR, ack);
        chk(ack, req, ack, 1);
        read_out(n, req);
        bus_stop();
    endtask

    task automatic bus_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d[$]);
        bit ack;
        bus_start();
        wbyte(DEVW, ack);
        chk(ack, "R4", ack, 1);
        wbyte(hi, ack);
        wbyte(lo, ack);
        foreach (d[i]) wbyte(d[i], ack);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        for (int i = 0; i <= MASK; i++) ref_mem[i] = 8'hFF;
        tick(20);
        rst_n = 1'b1;
        tick(5);
        // R1: reset state at the ports
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        chk(corrupt_o == 1'b0, "R1", corrupt_o, 0);
        rd_check(16'h0000, 2, "R1");

        // R2: strap mismatch is not acknowledged
        bus_start();
        wbyte(8'hA2, ack);
        chk(!ack, "R2", ack, 0);
        bus_stop();

        // R4 and R6: single byte write, poll while busy
        bus_write(8'h01, 8'h23, '{8'h5A});
        bus_stop();
        ref_put(16'h0123, '{8'h5A});
        bus_start();
        wbyte(DEVW, ack);
        chk(!ack, "R6", ack, 0);
        bus_stop();
        tick(WR + 100);
        rd_check(16'h0123, 1, "R4");

        // R5: page write wraps inside the page
        bus_write(8'h00, 8'h3E, '{8'h11, 8'h22, 8'h33, 8'h44});
        bus_stop();
        ref_put(16'h003E, '{8'h11, 8'h22, 8'h33, 8'h44});
        tick(WR + 100);
        rd_check(16'h003E, 2, "R5");
        rd_check(16'h0000, 3, "R5");

        // R8: current-address reads continue after last + 1
        bus_write(8'h01, 8'h00, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
        bus_stop();
        ref_put(16'h0100, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
        tick(WR + 100);
        rd_check(16'h0100, 1, "R8");
        cur_check(1, "R8");
        cur_check(2, "R8");

        // R7: sequential read wraps from the top address to zero
        bus_write(8'h3F, 8'hFF, '{8'hC3});
        bus_stop();
        ref_put(16'h3FFF, '{8'hC3});
        tick(WR + 100);
        rd_check(16'h3FFF, 3, "R7");

        // R4: top two bits of the high address byte are ignored
        bus_write(8'hC1, 8'h23, '{8'h77});
        bus_stop();
        ref_put(16'h0123, '{8'h77});
        tick(WR + 100);
        rd_check(16'h0123, 1, "R4");

        // R11: address-only write starts no cycle, loads the pointer
        bus_write(8'h01, 8'h01, '{});
        bus_stop();
        ref_ptr = 16'h0101;
        cur_check(1, "R11");

        // R9: protect raised after the first data byte cancels the write
        bus_write(8'h02, 8'h00, '{8'h12});
        wp = 1'b1; tick(20);
        wp = 1'b0; tick(5);
        bus_stop();
        rd_check(16'h0200, 1, "R9");

        // R10: protect during programming aborts and corrupts
        bus_write(8'h03, 8'h00, '{8'h01, 8'h02, 8'h03});
        bus_stop();
        tick(50);
        wp = 1'b1; tick(10);
        wp = 1'b0; tick(5);
        chk(corrupt_o == 1'b1, "R10", corrupt_o, 1);
        ref_put(16'h0300, '{8'hE7, 8'hE7, 8'hE7});
        rd_check(16'h0300, 4, "R10");

        // R10: flag clears when the next programming cycle starts
        bus_write(8'h04, 8'h00, '{8'h09});
        bus_stop();
        tick(5);
        chk(corrupt_o == 1'b0, "R10", corrupt_o, 0);
        ref_put(16'h0400, '{8'h09});
        tick(WR + 100);
        rd_check(16'h0400, 1, "R6");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule